// File: doc/BRIEF.md
# Prefix Index Register Unit

This block gives a register-less, two-address memory-to-memory instruction stream a way to index arrays without self-modifying code. It keeps one pending index value for the source address field and one for the destination address field. Four dedicated index-load opcodes write these values from the low 12 bits of a 16-bit fetched operand. The next ordinary instruction then has the pending values added to its 12-bit address fields and consumes them. The index loads therefore work as one-shot prefixes for the instruction that follows.

Two of the index loads are plain: they leave their own address fields untouched. The other two are source-modifiable: a pending source index is added to their own source field and is consumed, so two-level indexing can be chained. In every case only the address fields change. The opcode passes through unaltered. Memory access and execution sit outside the block. It takes the decoded opcode, both address fields, the operand and an issue strobe, and returns the effective fields one cycle after issue.

Top module: `prefix_index_unit`

## Requirements
- R1: After reset `out_valid_o` is 0 and neither index is pending, so the first ordinary instruction leaves the reset with its address fields unmodified.
- R2: An instruction issued with `issue_i`=1 appears on the outputs with `out_valid_o`=1 on the next cycle. A cycle without issue gives `out_valid_o`=0 on the next cycle and leaves both pending indexes unchanged.
- R3: `out_opcode_o` always equals the issued opcode. Index contents never alter it.
- R4: An index load stores bits [11:0] of `operand_i` as the pending value of its target index. Bits [15:12] are ignored.
- R5: Any opcode other than 0x48, 0x4A, 0x4C and 0x4E is ordinary. For an ordinary instruction, the effective source equals the source field plus the pending source index, if one is pending. The effective destination equals the destination field plus the pending destination index, if one is pending.
- R6: An ordinary instruction clears both pending indexes. A following ordinary instruction is then unmodified.
- R7: Opcodes 0x48 (load source index) and 0x4C (load destination index) output both of their own address fields unmodified, even when indexes are pending.
- R8: Opcode 0x48 leaves a pending destination index in place. Opcode 0x4C leaves a pending source index in place.
- R9: Opcodes 0x4A (load source index, source-modifiable) and 0x4E (load destination index, source-modifiable) add a pending source index to their own source field. Their destination field passes unmodified, and a pending destination index is ignored.
- R10: Opcode 0x4E consumes and clears a pending source index. Opcode 0x4A consumes it and replaces it with its own loaded value. Opcode 0x4A keeps a pending destination index pending.
- R11: Address sums are taken modulo 4096. A carry out of the 12-bit field is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | An instruction is presented this cycle |
| opcode_i | input | 8 | Decoded opcode byte |
| src_field_i | input | 12 | Source address field |
| dst_field_i | input | 12 | Destination address field |
| operand_i | input | 16 | Fetched 16-bit source operand (used by index loads) |
| out_valid_o | output | 1 | Effective fields valid for the instruction issued last cycle |
| out_opcode_o | output | 8 | Opcode of that instruction, unchanged |
| eff_src_o | output | 12 | Effective source address field |
| eff_dst_o | output | 12 | Effective destination address field |

## Verification
The assertions assume that `operand_i` carries the operand of an index load in the same cycle that the index load issues. They also assume that opcodes, fields and operand hold known values whenever `issue_i` is high. The stimulus drives all inputs at the falling edge, with a known value on every bus in every cycle, including idle ones. It issues instructions both back to back and separated by idle gaps. That covers pending indexes held across idle cycles as well as prefixes consumed in the very next cycle.

// File: rtl/pix_pkg.sv
package pix_pkg;

    // Opcode bytes of the four index-load instructions
    localparam logic [7:0] OPC_LD_SRC_FIX = 8'h48;
    localparam logic [7:0] OPC_LD_SRC_MOD = 8'h4A;
    localparam logic [7:0] OPC_LD_DST_FIX = 8'h4C;
    localparam logic [7:0] OPC_LD_DST_MOD = 8'h4E;

    // Per-instruction control derived from the opcode
    typedef struct packed {
        logic add_s;   // apply pending source index to source field
        logic add_d;   // apply pending destination index to destination field
        logic ld_s;    // write source index from operand
        logic ld_d;    // write destination index from operand
        logic clr_s;   // consume source index
        logic clr_d;   // consume destination index
    } pix_ctl_t;

    localparam int NUM_LANES = 2;
    localparam int LANE_SRC  = 0;
    localparam int LANE_DST  = 1;

endpackage

// File: rtl/pix_decode.sv
module pix_decode
    import pix_pkg::*;
#(
    parameter int OP_W = 8,
    parameter logic [OP_W-1:0] LD_SRC_FIX = OPC_LD_SRC_FIX,
    parameter logic [OP_W-1:0] LD_SRC_MOD = OPC_LD_SRC_MOD,
    parameter logic [OP_W-1:0] LD_DST_FIX = OPC_LD_DST_FIX,
    parameter logic [OP_W-1:0] LD_DST_MOD = OPC_LD_DST_MOD
) (
    input  logic [OP_W-1:0] opcode,
    output pix_ctl_t        ctl
);

    always_comb begin
        ctl = '0;
        unique case (opcode)
            LD_SRC_FIX: begin
                ctl.ld_s = 1'b1;
            end
            LD_DST_FIX: begin
                ctl.ld_d = 1'b1;
            end
            LD_SRC_MOD: begin
                ctl.add_s = 1'b1;
                ctl.clr_s = 1'b1;
                ctl.ld_s  = 1'b1;
            end
            LD_DST_MOD: begin
                ctl.add_s = 1'b1;
                ctl.clr_s = 1'b1;
                ctl.ld_d  = 1'b1;
            end
            default: begin
                ctl.add_s = 1'b1;
                ctl.add_d = 1'b1;
                ctl.clr_s = 1'b1;
                ctl.clr_d = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/pix_addr_adj.sv
module pix_addr_adj #(
    parameter int W = 12
) (
    input  logic [W-1:0] base,
    input  logic [W-1:0] idx,
    input  logic         en,
    output logic [W-1:0] sum
);

    logic [W-1:0] addend;

    always_comb begin
        addend = en ? idx : '0;
        sum    = base + addend;   // carry out dropped: modulo 2**W
    end

endmodule

// File: rtl/pix_index_bank.sv
module pix_index_bank
    import pix_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int OPND_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  pix_ctl_t          ctl,
    input  logic [OPND_W-1:0] operand,
    output logic [ADDR_W-1:0] sidx,
    output logic              sset,
    output logic [ADDR_W-1:0] didx,
    output logic              dset
);

    typedef struct packed {
        logic [ADDR_W-1:0] sidx;
        logic              sset;
        logic [ADDR_W-1:0] didx;
        logic              dset;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [ADDR_W-1:0] opnd_low;

    assign opnd_low = operand[ADDR_W-1:0];

    always_comb begin
        bank_d = bank_q;
        if (issue) begin
            if (ctl.ld_s) begin
                bank_d.sidx = opnd_low;
                bank_d.sset = 1'b1;
            end else if (ctl.clr_s) begin
                bank_d.sidx = '0;
                bank_d.sset = 1'b0;
            end
            if (ctl.ld_d) begin
                bank_d.didx = opnd_low;
                bank_d.dset = 1'b1;
            end else if (ctl.clr_d) begin
                bank_d.didx = '0;
                bank_d.dset = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign sidx = bank_q.sidx;
    assign sset = bank_q.sset;
    assign didx = bank_q.didx;
    assign dset = bank_q.dset;

    // R4
    load_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && ctl.ld_s) |=> (sset && sidx == $past(operand[ADDR_W-1:0])));

    // R4
    load_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && ctl.ld_d) |=> (dset && didx == $past(operand[ADDR_W-1:0])));

    // R6
    consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && ctl.clr_d && !ctl.ld_s) |=> (!sset && !dset));

    // R8
    keep_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !ctl.ld_d && !ctl.clr_d) |=> ($stable(dset) && $stable(didx)));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> ($stable(sset) && $stable(sidx) && $stable(dset) && $stable(didx)));

endmodule

// File: rtl/prefix_index_unit.sv
module prefix_index_unit
    import pix_pkg::*;
#(
    parameter int OP_W   = 8,
    parameter int ADDR_W = 12,
    parameter int OPND_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_i,
    input  logic [OP_W-1:0]   opcode_i,
    input  logic [ADDR_W-1:0] src_field_i,
    input  logic [ADDR_W-1:0] dst_field_i,
    input  logic [OPND_W-1:0] operand_i,
    output logic              out_valid_o,
    output logic [OP_W-1:0]   out_opcode_o,
    output logic [ADDR_W-1:0] eff_src_o,
    output logic [ADDR_W-1:0] eff_dst_o
);

    typedef struct packed {
        logic              vld;
        logic [OP_W-1:0]   op;
        logic [ADDR_W-1:0] esrc;
        logic [ADDR_W-1:0] edst;
    } out_t;

    pix_ctl_t          ctl;
    logic [ADDR_W-1:0] sidx, didx;
    logic              sset, dset;
    logic [ADDR_W-1:0] lane_base [NUM_LANES];
    logic [ADDR_W-1:0] lane_idx  [NUM_LANES];
    logic              lane_en   [NUM_LANES];
    logic [ADDR_W-1:0] lane_sum  [NUM_LANES];
    out_t              out_d, out_q;

    pix_decode #(
        .OP_W(OP_W)
    ) u_decode (
        .opcode(opcode_i),
        .ctl   (ctl)
    );

    pix_index_bank #(
        .ADDR_W(ADDR_W),
        .OPND_W(OPND_W)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .issue  (issue_i),
        .ctl    (ctl),
        .operand(operand_i),
        .sidx   (sidx),
        .sset   (sset),
        .didx   (didx),
        .dset   (dset)
    );

    always_comb begin
        lane_base[LANE_SRC] = src_field_i;
        lane_idx[LANE_SRC]  = sidx;
        lane_en[LANE_SRC]   = ctl.add_s && sset;
        lane_base[LANE_DST] = dst_field_i;
        lane_idx[LANE_DST]  = didx;
        lane_en[LANE_DST]   = ctl.add_d && dset;
    end

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        pix_addr_adj #(
            .W(ADDR_W)
        ) u_adj (
            .base(lane_base[g]),
            .idx (lane_idx[g]),
            .en  (lane_en[g]),
            .sum (lane_sum[g])
        );
    end

    always_comb begin
        out_d     = out_q;
        out_d.vld = issue_i;
        if (issue_i) begin
            out_d.op   = opcode_i;
            out_d.esrc = lane_sum[LANE_SRC];
            out_d.edst = lane_sum[LANE_DST];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid_o  = out_q.vld;
    assign out_opcode_o = out_q.op;
    assign eff_src_o    = out_q.esrc;
    assign eff_dst_o    = out_q.edst;

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i |=> out_valid_o);

    // R2
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_i |=> !out_valid_o);

    // R3
    opcode_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i |=> (out_opcode_o == $past(opcode_i)));

    // R7
    fixed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && (ctl.ld_s || ctl.ld_d) && !ctl.add_s)
        |=> (eff_src_o == $past(src_field_i) && eff_dst_o == $past(dst_field_i)));

    // R9
    mod_load_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && ctl.add_s && !ctl.add_d) |=> (eff_dst_o == $past(dst_field_i)));

    // R6
    no_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && !sset && !dset && ctl.add_d)
        |=> (eff_src_o == $past(src_field_i) && eff_dst_o == $past(dst_field_i)));

endmodule

// File: tb/prefix_index_unit_bench.sv
module prefix_index_unit_bench;

    typedef struct {
        logic [7:0]  op;
        logic [11:0] es;
        logic [11:0] ed;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_i = 1'b0;
    logic [7:0]  opcode_i = '0;
    logic [11:0] src_field_i = '0;
    logic [11:0] dst_field_i = '0;
    logic [15:0] operand_i = '0;
    logic        out_valid_o;
    logic [7:0]  out_opcode_o;
    logic [11:0] eff_src_o;
    logic [11:0] eff_dst_o;

    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    // bench-side model of pending indexes
    logic [11:0] m_sidx = '0;
    logic [11:0] m_didx = '0;
    bit          m_sset = 1'b0;
    bit          m_dset = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    prefix_index_unit u_prefix_index_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_i     (issue_i),
        .opcode_i    (opcode_i),
        .src_field_i (src_field_i),
        .dst_field_i (dst_field_i),
        .operand_i   (operand_i),
        .out_valid_o (out_valid_o),
        .out_opcode_o(out_opcode_o),
        .eff_src_o   (eff_src_o),
        .eff_dst_o   (eff_dst_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // driver: issue one instruction and push its expected result
    task automatic send(input logic [7:0] op, input logic [11:0] s, input logic [11:0] d,
                        input logic [15:0] opnd, input string req);
        exp_t e;
        logic [11:0] addS, addD;
        @(negedge clk);
        issue_i = 1'b1;
        opcode_i = op;
        src_field_i = s;
        dst_field_i = d;
        operand_i = opnd;
        addS = m_sset ? m_sidx : 12'h000;
        addD = m_dset ? m_didx : 12'h000;
        e.op = op;
        e.req = req;
        case (op)
            8'h48: begin
                e.es = s; e.ed = d;
                m_sidx = opnd[11:0]; m_sset = 1'b1;
            end
            8'h4C: begin
                e.es = s; e.ed = d;
                m_didx = opnd[11:0]; m_dset = 1'b1;
            end
            8'h4A: begin
                e.es = s + addS; e.ed = d;
                m_sidx = opnd[11:0]; m_sset = 1'b1;
            end
            8'h4E: begin
                e.es = s + addS; e.ed = d;
                m_sidx = '0; m_sset = 1'b0;
                m_didx = opnd[11:0]; m_dset = 1'b1;
            end
            default: begin
                e.es = s + addS; e.ed = d + addD;
                m_sidx = '0; m_sset = 1'b0;
                m_didx = '0; m_dset = 1'b0;
            end
        endcase
        sb.push_back(e);
    endtask

    // idle cycles; the second idle edge shows out_valid_o low (R2)
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            issue_i = 1'b0;
            opcode_i = 8'hA5;
            src_field_i = 12'h5A5;
            dst_field_i = 12'hA5A;
            operand_i = 16'hFFFF;
            if (i >= 1) check(out_valid_o == 1'b0, "R2", "valid when idle", out_valid_o, 0);
        end
    endtask

    // monitor: pop and compare
    always @(negedge clk) begin
        if (rst_n && out_valid_o) begin
            if (sb.size() == 0) begin
                check(1'b0, "R2", "unexpected valid", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(out_opcode_o == e.op, "R3", "opcode", out_opcode_o, e.op);
                check(eff_src_o == e.es, e.req, "eff_src", eff_src_o, e.es);
                check(eff_dst_o == e.ed, e.req, "eff_dst", eff_dst_o, e.ed);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid_o == 1'b0, "R1", "valid in reset", out_valid_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid_o == 1'b0, "R1", "valid after reset", out_valid_o, 0);

        // R1: first ordinary after reset unmodified
        send(8'h01, 12'h123, 12'h456, 16'h0000, "R1");
        idle(2);

        // R4, R5: source index with upper operand bits ignored
        send(8'h48, 12'h010, 12'h020, 16'hF123, "R7");
        send(8'h21, 12'h010, 12'h020, 16'h0000, "R5");
        // R6: registers consumed
        send(8'h21, 12'h010, 12'h020, 16'h0000, "R6");
        idle(2);

        // R2: destination index survives idle cycles
        send(8'h4C, 12'h001, 12'h002, 16'h0400, "R7");
        idle(4);
        send(8'h60, 12'h000, 12'h030, 16'h0000, "R2");

        // R8: 0x4C keeps pending source; 0x48 keeps pending destination
        send(8'h48, 12'h100, 12'h200, 16'h0005, "R7");
        send(8'h4C, 12'h300, 12'h400, 16'h0007, "R8");
        send(8'h80, 12'h010, 12'h010, 16'h0000, "R8");
        send(8'h4C, 12'h000, 12'h000, 16'h0009, "R7");
        send(8'h48, 12'h000, 12'h000, 16'h000B, "R8");
        send(8'h81, 12'h001, 12'h001, 16'h0000, "R8");

        // R9, R10: 0x4A adds pending source, reloads it, keeps destination
        send(8'h4C, 12'h000, 12'h000, 16'h0055, "R7");
        send(8'h48, 12'h000, 12'h000, 16'h0010, "R7");
        send(8'h4A, 12'h100, 12'h777, 16'h0066, "R9");
        send(8'h90, 12'h000, 12'h100, 16'h0000, "R10");

        // R9, R10: 0x4E adds pending source then clears it
        send(8'h4C, 12'h000, 12'h000, 16'h0030, "R7");
        send(8'h48, 12'h000, 12'h000, 16'h0011, "R7");
        send(8'h4E, 12'h200, 12'h333, 16'h0044, "R9");
        send(8'h91, 12'h000, 12'h000, 16'h0000, "R10");

        // R9: modifiable load with nothing pending
        send(8'h4A, 12'h0AB, 12'h0CD, 16'h0001, "R9");
        send(8'h92, 12'h000, 12'h000, 16'h0000, "R4");

        // R11: carries dropped
        send(8'h48, 12'h000, 12'h000, 16'h0FFF, "R7");
        send(8'h4C, 12'h000, 12'h000, 16'h0800, "R7");
        send(8'hA0, 12'h002, 12'h900, 16'h0000, "R11");

        // R3, R5: opcodes adjacent to the index loads are ordinary
        send(8'h48, 12'h000, 12'h000, 16'h0003, "R7");
        send(8'h49, 12'h010, 12'h010, 16'h0000, "R5");
        send(8'h4C, 12'h000, 12'h000, 16'h0004, "R7");
        send(8'h4F, 12'h010, 12'h010, 16'h0000, "R5");
        send(8'hC1, 12'hFFF, 12'hFFF, 16'h0000, "R6");
        idle(3);

        check(sb.size() == 0, "R2", "results outstanding", sb.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R2 watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule